// File: doc/BRIEF.md
# Inter-processor flag handshake registers

A bank of 32 event flags lets one processor (the sender) signal another (the receiver) through two small register ports. Each port has its own address, write data, write enable, read strobe and read data, and both run on one shared clock. The sender raises flags by writing ones to a strobe register. The receiver consumes them by writing ones to an acknowledge register. Both registers are write-one-only and read back as zero. The flag state has one store, and each side sees it through its own read-only view: the flag view on the sender port and the status view on the receiver port.

The four lowest flags also drive level interrupt lines toward the receiver. The remaining flags must be polled. If a set and an acknowledge hit the same flag in the same cycle, the set wins, so a fresh event is never lost.

Top module: `ipc_flag_bank`

## Requirements
- R1: Flag n (1..32) lives in bit n-1. Writing a 1 to a bit of the sender strobe register (sender offset 0) sets that flag at the next clock edge.
- R2: Writing 0 to a sender strobe bit leaves that flag unchanged.
- R3: Writing a 1 to a bit of the receiver acknowledge register (receiver offset 0) clears that flag at the next clock edge. The cleared bit shows as 0 in both the sender flag view and the receiver status view.
- R4: Writing 0 to an acknowledge bit leaves that flag unchanged.
- R5: Reading the sender strobe register or the receiver acknowledge register returns 0 whatever the flag state.
- R6: The sender flag view (sender offset 1) and the receiver status view (receiver offset 1) always return identical contents. Writes to either view are ignored.
- R7: After reset all flags, all interrupt lines and both read data buses are 0.
- R8: A set and an acknowledge of the same bit in the same cycle leave the flag at 1.
- R9: Interrupt line k (k = 0..3) is high exactly while flag k+1 is 1. It drops right after the clock edge that takes the acknowledge. Flags 5..32 drive no interrupt.
- R10: Read data is registered. In the cycle after a read strobe it carries the addressed value as it stood at the strobe edge. In any other cycle, and for unmapped offsets (2 and above), it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_addr | input | ADDR_W | Sender register offset |
| snd_wdata | input | NUM_FLAGS | Sender write data |
| snd_we | input | 1 | Sender write enable |
| snd_re | input | 1 | Sender read strobe |
| snd_rdata | output | NUM_FLAGS | Sender read data, one cycle after strobe |
| rcv_addr | input | ADDR_W | Receiver register offset |
| rcv_wdata | input | NUM_FLAGS | Receiver write data |
| rcv_we | input | 1 | Receiver write enable |
| rcv_re | input | 1 | Receiver read strobe |
| rcv_rdata | output | NUM_FLAGS | Receiver read data, one cycle after strobe |
| rcv_irq | output | NUM_IRQ | Level interrupts for the lowest flags |

## Verification
The bench aims at a same-cycle set and acknowledge of one bit. A design that let the clear win would lose the event and leave the flag at 0. It writes all ones into both read-only views; a design that decoded those offsets as strobes would change the flags. It reads the strobe and acknowledge offsets while flags are set, which would catch a design that returned the flag state there. It samples the interrupt line on each side of an acknowledge, and raises a high flag with no interrupt, to catch a late drop or an interrupt mapped to the wrong flag.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;

  // Offsets shared by both ports: strobe (set/ack) and read-only view.
  localparam int unsigned STROBE_OFS = 0;
  localparam int unsigned VIEW_OFS   = 1;

  typedef enum logic [1:0] {
    ROLE_NONE   = 2'd0,
    ROLE_STROBE = 2'd1,
    ROLE_VIEW   = 2'd2
  } reg_role_e;

  function automatic reg_role_e role_of(input int unsigned ofs);
    if (ofs == STROBE_OFS)    return ROLE_STROBE;
    else if (ofs == VIEW_OFS) return ROLE_VIEW;
    else                      return ROLE_NONE;
  endfunction

endpackage

// File: rtl/ipc_port_decode.sv
module ipc_port_decode
  import ipc_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] view_data,
  output logic [DATA_W-1:0] strobe_vec,
  output logic [DATA_W-1:0] rdata
);

  reg_role_e         role;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_sel;

  always_comb role = role_of(int'(addr));

  // Write-one strobe: only the strobe offset produces a pulse vector.
  assign strobe_vec = (we && role == ROLE_STROBE) ? wdata : '0;

  // Strobe offset and unmapped offsets read as zero.
  always_comb begin
    rd_sel = '0;
    if (role == ROLE_VIEW) rd_sel = view_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= rd_sel;
    else         rdata_q <= '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ipc_flag_store.sv
module ipc_flag_store #(
  parameter int unsigned NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic [NUM_FLAGS-1:0] ack_vec,
  output logic [NUM_FLAGS-1:0] flags_q
);

  // Clear first, then set: a coincident set survives the acknowledge.
  function automatic logic [NUM_FLAGS-1:0] flag_next(
    input logic [NUM_FLAGS-1:0] cur,
    input logic [NUM_FLAGS-1:0] set_m,
    input logic [NUM_FLAGS-1:0] ack_m
  );
    return (cur & ~ack_m) | set_m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flag_next(flags_q, set_vec, ack_vec);
  end

endmodule

// File: rtl/ipc_irq_map.sv
module ipc_irq_map #(
  parameter int unsigned NUM_FLAGS = 32,
  parameter int unsigned NUM_IRQ   = 4
) (
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_IRQ-1:0]   irq
);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assign irq[k] = flags[k];
  end

endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank #(
  parameter int unsigned NUM_FLAGS = 32,
  parameter int unsigned NUM_IRQ   = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    snd_addr,
  input  logic [NUM_FLAGS-1:0] snd_wdata,
  input  logic                 snd_we,
  input  logic                 snd_re,
  output logic [NUM_FLAGS-1:0] snd_rdata,
  input  logic [ADDR_W-1:0]    rcv_addr,
  input  logic [NUM_FLAGS-1:0] rcv_wdata,
  input  logic                 rcv_we,
  input  logic                 rcv_re,
  output logic [NUM_FLAGS-1:0] rcv_rdata,
  output logic [NUM_IRQ-1:0]   rcv_irq
);

  // Named internal events, visible to the bound checker.
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] ack_vec;
  logic [NUM_FLAGS-1:0] flags_q;

  ipc_port_decode #(.ADDR_W(ADDR_W), .DATA_W(NUM_FLAGS)) snd_dec_i (
    .clk(clk), .rst_n(rst_n), .addr(snd_addr), .wdata(snd_wdata),
    .we(snd_we), .re(snd_re), .view_data(flags_q),
    .strobe_vec(set_vec), .rdata(snd_rdata)
  );

  ipc_port_decode #(.ADDR_W(ADDR_W), .DATA_W(NUM_FLAGS)) rcv_dec_i (
    .clk(clk), .rst_n(rst_n), .addr(rcv_addr), .wdata(rcv_wdata),
    .we(rcv_we), .re(rcv_re), .view_data(flags_q),
    .strobe_vec(ack_vec), .rdata(rcv_rdata)
  );

  ipc_flag_store #(.NUM_FLAGS(NUM_FLAGS)) store_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .ack_vec(ack_vec),
    .flags_q(flags_q)
  );

  ipc_irq_map #(.NUM_FLAGS(NUM_FLAGS), .NUM_IRQ(NUM_IRQ)) irq_i (
    .flags(flags_q), .irq(rcv_irq)
  );

endmodule

// File: rtl/ipc_flag_bank_chk.sv
module ipc_flag_bank_chk
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 32,
  parameter int unsigned NUM_IRQ   = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    snd_addr,
  input logic                 snd_re,
  input logic [NUM_FLAGS-1:0] snd_rdata,
  input logic [ADDR_W-1:0]    rcv_addr,
  input logic                 rcv_re,
  input logic [NUM_FLAGS-1:0] rcv_rdata,
  input logic [NUM_IRQ-1:0]   rcv_irq,
  input logic [NUM_FLAGS-1:0] set_vec,
  input logic [NUM_FLAGS-1:0] ack_vec,
  input logic [NUM_FLAGS-1:0] flags_q
);

  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> (($past(set_vec) & ~flags_q) == '0));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_vec & ~set_vec)) |=> (($past(ack_vec & ~set_vec) & flags_q) == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && ack_vec == '0) |=> $stable(flags_q));

  // R5
  snd_strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_re && snd_addr == ADDR_W'(STROBE_OFS)) |=> (snd_rdata == '0));

  // R5
  rcv_strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_re && rcv_addr == ADDR_W'(STROBE_OFS)) |=> (rcv_rdata == '0));

  // R6
  views_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_re && snd_addr == ADDR_W'(VIEW_OFS) && rcv_re && rcv_addr == ADDR_W'(VIEW_OFS))
    |=> (snd_rdata == rcv_rdata));

  // R9
  irq_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rcv_irq & ~$past(rcv_irq))) |-> (|$past(set_vec[NUM_IRQ-1:0])));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snd_re && !rcv_re) |=> (snd_rdata == '0 && rcv_rdata == '0));

endmodule

bind ipc_flag_bank ipc_flag_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .snd_addr(snd_addr), .snd_re(snd_re), .snd_rdata(snd_rdata),
  .rcv_addr(rcv_addr), .rcv_re(rcv_re), .rcv_rdata(rcv_rdata),
  .rcv_irq(rcv_irq), .set_vec(set_vec), .ack_vec(ack_vec), .flags_q(flags_q)
);

// File: tb/ipc_flag_bank_tb_top.sv
module ipc_flag_bank_tb_top;

  localparam int unsigned NF = 32;
  localparam int unsigned NI = 4;
  localparam int unsigned AW = 4;
  localparam int unsigned NVEC = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] snd_addr = '0, rcv_addr = '0;
  logic [NF-1:0] snd_wdata = '0, rcv_wdata = '0;
  logic          snd_we = 1'b0, snd_re = 1'b0, rcv_we = 1'b0, rcv_re = 1'b0;
  logic [NF-1:0] snd_rdata, rcv_rdata;
  logic [NI-1:0] rcv_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ipc_flag_bank #(.NUM_FLAGS(NF), .NUM_IRQ(NI), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .snd_addr(snd_addr), .snd_wdata(snd_wdata), .snd_we(snd_we), .snd_re(snd_re),
    .snd_rdata(snd_rdata),
    .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata), .rcv_we(rcv_we), .rcv_re(rcv_re),
    .rcv_rdata(rcv_rdata), .rcv_irq(rcv_irq)
  );

  // {is_ack, write data, expected flags afterwards}
  localparam logic [64:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_0001, 32'h0000_0001},  // R1
    {1'b0, 32'h8000_0010, 32'h8000_0011},  // R1 top and middle
    {1'b0, 32'h0000_0000, 32'h8000_0011},  // R2 zero set
    {1'b1, 32'h0000_0000, 32'h8000_0011},  // R4 zero ack
    {1'b1, 32'h0000_0001, 32'h8000_0010},  // R3
    {1'b0, 32'h0000_000E, 32'h8000_001E},
    {1'b1, 32'hFFFF_FFF0, 32'h0000_000E},
    {1'b1, 32'h0000_000A, 32'h0000_0004},
    {1'b0, 32'h5A5A_0000, 32'h5A5A_0004},
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [NF-1:0] act, input logic [NF-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit rcv, input int unsigned ofs, input logic [NF-1:0] d);
    @(negedge clk);
    if (rcv) begin rcv_addr = AW'(ofs); rcv_wdata = d; rcv_we = 1'b1; end
    else     begin snd_addr = AW'(ofs); snd_wdata = d; snd_we = 1'b1; end
    @(negedge clk);
    rcv_we = 1'b0; snd_we = 1'b0;
  endtask

  task automatic rd(input bit rcv, input int unsigned ofs, output logic [NF-1:0] d);
    @(negedge clk);
    if (rcv) begin rcv_addr = AW'(ofs); rcv_re = 1'b1; end
    else     begin snd_addr = AW'(ofs); snd_re = 1'b1; end
    @(negedge clk);
    rcv_re = 1'b0; snd_re = 1'b0;
    d = rcv ? rcv_rdata : snd_rdata;
  endtask

  task automatic check_views(input string req, input logic [NF-1:0] exp);
    logic [NF-1:0] v;
    rd(1'b0, 1, v); check({req, " flag view"}, v, exp);
    rd(1'b1, 1, v); check({req, " status view"}, v, exp);
    check({req, " irq R9"}, NF'(rcv_irq), NF'(exp[NI-1:0]));
  endtask

  initial begin
    logic [NF-1:0] v;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 irq", NF'(rcv_irq), '0);
    check("R7 snd_rdata", snd_rdata, '0);
    check("R7 rcv_rdata", rcv_rdata, '0);
    rst_n = 1'b1;
    check_views("R7", '0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][64], 0, VEC[i][63:32]);
      check_views(VEC[i][64] ? "R3/R4" : "R1/R2", VEC[i][31:0]);
    end

    // R5 strobe registers read zero with flags set
    wr(1'b0, 0, 32'h0000_0013);
    rd(1'b0, 0, v); check("R5 set reads", v, '0);
    rd(1'b1, 0, v); check("R5 ack reads", v, '0);

    // R6 writes to views ignored; simultaneous reads agree
    wr(1'b0, 1, '1);
    wr(1'b1, 1, '1);
    check_views("R6", 32'h0000_0013);
    @(negedge clk);
    snd_addr = AW'(1); rcv_addr = AW'(1); snd_re = 1'b1; rcv_re = 1'b1;
    @(negedge clk);
    snd_re = 1'b0; rcv_re = 1'b0;
    check("R6 same-cycle", snd_rdata, rcv_rdata);

    // R10 unmapped offset reads zero, idle read bus zero
    rd(1'b0, 5, v); check("R10 snd unmapped", v, '0);
    rd(1'b1, 9, v); check("R10 rcv unmapped", v, '0);
    @(negedge clk);
    check("R10 idle", snd_rdata | rcv_rdata, '0);

    // R9 flag 5 raises no irq; ack drops irq right after the edge
    check("R9 flag5 no irq", NF'(rcv_irq), NF'(4'b0011));
    check("R9 irq before ack", NF'(rcv_irq[1]), NF'(1'b1));
    wr(1'b1, 0, 32'h0000_0002);
    check("R9 irq after ack", NF'(rcv_irq[1]), '0);

    // R8 set and ack same bit same cycle
    @(negedge clk);
    snd_addr = AW'(0); snd_wdata = 32'h0000_0004; snd_we = 1'b1;
    rcv_addr = AW'(0); rcv_wdata = 32'h0000_0005; rcv_we = 1'b1;
    @(negedge clk);
    snd_we = 1'b0; rcv_we = 1'b0;
    check_views("R8", 32'h0000_0014);

    // R7 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_views("R7 re-reset", '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule